// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block builds the eight-bit status byte of a remotely controlled instrument and decides when to raise a service request toward the bus controller. It has three summary sources. The first is an output-queue-not-empty flag. The second is a latched standard event register with its own enable mask. The third is a wider latched operation event register with its own enable mask. Each event register collects set pulses and holds them until a clear-status strobe arrives. Each event register then reduces to one summary bit through its enable mask.

A service request enable mask selects which status bits feed the master summary. A rising edge of that summary latches a request-service flag, and the flag drives the service request line.

Two read paths capture the byte on a strobe. A serial poll snapshot carries the latched request flag in bit 6, and the poll consumes that flag. A status query snapshot carries the live master summary in bit 6 and leaves every piece of state untouched. Each snapshot holds until its own strobe comes again.

Top module: `status_byte_srq`

## Requirements
- R1: Bits 3..0 of both captured bytes always read 0.
- R2: Bit 4 (weight 16) carries `mav_i`, the output-queue-not-empty flag. It is taken in the cycle of the strobe, and a serial poll does not clear it.
- R3: Bit 5 (weight 32) is 1 exactly when some bit is set in both the standard event register and `std_en_i`.
- R4: Bit 7 (weight 128) is 1 exactly when some bit is set in both the operation event register and `oper_en_i`.
- R5: The master summary is the OR of status bits 7, 5, 4 and 3..0, each ANDed with the same-numbered bit of `sre_i`. Bit 6 of `sre_i` has no effect.
- R6: One clock edge after the master summary rises, the request flag is set, and `srq_o` is high exactly while that flag is set.
- R7: A `poll_i` cycle captures the status byte into `poll_byte_o` at the next edge, with the request flag before clearing in bit 6, and clears only the request flag. If a summary rise coincides with the poll, the new request wins and the flag stays set.
- R8: A `query_i` cycle captures the status byte into `query_byte_o` at the next edge, with the live master summary in bit 6. It changes no state.
- R9: Once the request flag has been cleared, it is not set again while the summary stays high. It is set again only after the summary falls and then rises.
- R10: A `clr_i` cycle zeroes both event registers and the request flag at the next edge. It overrides event set pulses in that same cycle and leaves all masks unchanged.
- R11: Event set pulses are sticky. A bit stays set after its pulse ends, until `clr_i`.
- R12: While reset is asserted, both captured bytes and `srq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mav_i | input | 1 | Output queue holds unread data |
| std_set_i | input | STD_W | Standard event set pulses |
| std_en_i | input | STD_W | Standard event enable mask |
| oper_set_i | input | OPER_W | Operation event set pulses |
| oper_en_i | input | OPER_W | Operation event enable mask |
| sre_i | input | 8 | Service request enable mask |
| poll_i | input | 1 | Serial poll strobe |
| query_i | input | 1 | Status query strobe |
| clr_i | input | 1 | Clear-status strobe |
| poll_byte_o | output | 8 | Byte captured by the last serial poll |
| query_byte_o | output | 8 | Byte captured by the last status query |
| srq_o | output | 1 | Service request line |

## Verification
The bench builds the block with its defaults: an eight-bit standard register and a sixteen-bit operation register. These widths let it set the top operation bit 15 and confirm that the whole vector reaches the summary. They also let it pulse a disabled standard bit next to an enabled one, to show that the mask matters. The stimulus covers several edge cases:
- a poll that lands in the same cycle as a summary rise;
- a clear that lands in the same cycle as a set pulse;
- an enable mask that has only bit 6 set, which must never produce a request.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int MAV_BIT = 4;
  localparam int ESB_BIT = 5;
  localparam int RQS_BIT = 6;
  localparam int OSB_BIT = 7;

  function automatic logic [7:0] pack_byte(logic osb, logic b6, logic esb, logic mav);
    logic [7:0] b;
    b = '0;
    b[OSB_BIT] = osb;
    b[RQS_BIT] = b6;
    b[ESB_BIT] = esb;
    b[MAV_BIT] = mav;
    return b;
  endfunction
endpackage

// File: rtl/stb_evt_reg.sv
module stb_evt_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] q_o,
  output logic         summ_o
);
  logic [W-1:0] q;

  // clear beats same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else            q <= q | set_i;
  end

  assign q_o    = q;
  assign summ_o = |(q & en_i);
endmodule

// File: rtl/stb_summary.sv
module stb_summary
  import stb_pkg::*;
(
  input  logic       mav_i,
  input  logic       esb_i,
  input  logic       osb_i,
  input  logic [7:0] sre_i,
  output logic [7:0] stat_o,
  output logic       mss_o
);
  localparam logic [7:0] SRE_USE = ~(8'(1) << RQS_BIT);

  assign stat_o = pack_byte(osb_i, 1'b0, esb_i, mav_i);
  assign mss_o  = |(stat_o & sre_i & SRE_USE);
endmodule

// File: rtl/stb_rqs.sv
module stb_rqs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic poll_i,
  input  logic mss_i,
  output logic rqs_o
);
  logic mss_q, rqs_q, rise;

  assign rise = mss_i & ~mss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss_i;
      if (clr_i)       rqs_q <= 1'b0;
      else if (rise)   rqs_q <= 1'b1;  // new request beats poll
      else if (poll_i) rqs_q <= 1'b0;
    end
  end

  assign rqs_o = rqs_q;
endmodule

// File: rtl/status_byte_srq.sv
module status_byte_srq
  import stb_pkg::*;
#(
  parameter int STD_W  = 8,
  parameter int OPER_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mav_i,
  input  logic [STD_W-1:0]  std_set_i,
  input  logic [STD_W-1:0]  std_en_i,
  input  logic [OPER_W-1:0] oper_set_i,
  input  logic [OPER_W-1:0] oper_en_i,
  input  logic [7:0]        sre_i,
  input  logic              poll_i,
  input  logic              query_i,
  input  logic              clr_i,
  output logic [7:0]        poll_byte_o,
  output logic [7:0]        query_byte_o,
  output logic              srq_o
);
  logic [STD_W-1:0]  std_q;
  logic [OPER_W-1:0] oper_q;
  logic              esb, osb, mss, rqs;
  logic [7:0]        stat;
  logic [7:0]        poll_q, query_q;

  stb_evt_reg #(.W(STD_W)) u_std (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .set_i(std_set_i), .en_i(std_en_i), .q_o(std_q), .summ_o(esb)
  );

  stb_evt_reg #(.W(OPER_W)) u_oper (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .set_i(oper_set_i), .en_i(oper_en_i), .q_o(oper_q), .summ_o(osb)
  );

  stb_summary u_sum (
    .mav_i(mav_i), .esb_i(esb), .osb_i(osb), .sre_i(sre_i),
    .stat_o(stat), .mss_o(mss)
  );

  stb_rqs u_rqs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .poll_i(poll_i), .mss_i(mss), .rqs_o(rqs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q  <= '0;
      query_q <= '0;
    end else begin
      if (poll_i)  poll_q  <= stat | (8'(rqs) << RQS_BIT);
      if (query_i) query_q <= stat | (8'(mss) << RQS_BIT);
    end
  end

  assign poll_byte_o  = poll_q;
  assign query_byte_o = query_q;
  assign srq_o        = rqs;
endmodule

// File: rtl/stb_chk.sv
module stb_chk #(
  parameter int STD_W  = 8,
  parameter int OPER_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              poll_i,
  input logic              query_i,
  input logic              clr_i,
  input logic              mss,
  input logic [STD_W-1:0]  std_q,
  input logic [OPER_W-1:0] oper_q,
  input logic [7:0]        poll_byte_o,
  input logic [7:0]        query_byte_o,
  input logic              srq_o
);
  // R6
  srq_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mss) && !clr_i) |=> srq_o);

  // R7
  poll_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i |=> (poll_byte_o[6] == $past(srq_o)));

  // R8
  query_bit6_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_i |=> (query_byte_o[6] == $past(mss)));

  // R8
  query_keeps_srq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_i && !poll_i && !clr_i && srq_o) |=> srq_o);

  // R10
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!srq_o && std_q == '0 && oper_q == '0));

  // R7
  poll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_i |=> $stable(poll_byte_o));
endmodule

bind status_byte_srq stb_chk #(.STD_W(STD_W), .OPER_W(OPER_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .poll_i(poll_i), .query_i(query_i),
  .clr_i(clr_i), .mss(mss), .std_q(std_q), .oper_q(oper_q),
  .poll_byte_o(poll_byte_o), .query_byte_o(query_byte_o), .srq_o(srq_o)
);

// File: tb/sim_status_byte_srq.sv
module sim_status_byte_srq;
  timeunit 1ns; timeprecision 100ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mav = 0, poll = 0, query = 0, clr = 0;
  logic [7:0]  std_set = 0, std_en = 0, sre = 0;
  logic [15:0] oper_set = 0, oper_en = 0;
  logic [7:0]  poll_byte, query_byte;
  logic        srq;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0]  m_std = 0, m_pb = 0, m_qb = 0;
  logic [15:0] m_oper = 0;
  logic        m_rqs = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  status_byte_srq u0 (
    .clk_i(clk), .rst_ni(rst_n), .mav_i(mav),
    .std_set_i(std_set), .std_en_i(std_en),
    .oper_set_i(oper_set), .oper_en_i(oper_en),
    .sre_i(sre), .poll_i(poll), .query_i(query), .clr_i(clr),
    .poll_byte_o(poll_byte), .query_byte_o(query_byte), .srq_o(srq)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte(logic b6);
    logic [7:0] b;
    b = 8'h00;
    b[7] = (m_oper & oper_en) != 0;
    b[6] = b6;
    b[5] = (m_std & std_en) != 0;
    b[4] = mav;
    return b;
  endfunction

  task automatic step(string req);
    logic [7:0] st;
    logic       mss, rqs_n;
    @(posedge clk);
    st  = model_byte(1'b0);
    mss = (st & sre & 8'hBF) != 0;
    rqs_n = m_rqs;
    if (clr)                rqs_n = 1'b0;
    else if (mss && !m_prev) rqs_n = 1'b1;
    else if (poll)          rqs_n = 1'b0;
    if (poll)  m_pb = model_byte(m_rqs);
    if (query) m_qb = model_byte(mss);
    m_rqs  = rqs_n;
    m_prev = mss;
    m_std  = clr ? 8'h00  : (m_std | std_set);
    m_oper = clr ? 16'h0  : (m_oper | oper_set);
    #1;
    chk(req, "poll_byte", poll_byte, m_pb);
    chk(req, "query_byte", query_byte, m_qb);
    chk(req, "srq", {7'b0, srq}, {7'b0, m_rqs});
    @(negedge clk);
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic do_poll(string req);
    poll = 1; step(req); poll = 0;
  endtask

  task automatic do_query(string req);
    query = 1; step(req); query = 0;
  endtask

  initial begin
    #12;
    chk("R12", "reset poll_byte", poll_byte, 8'h00);
    chk("R12", "reset query_byte", query_byte, 8'h00);
    chk("R12", "reset srq", {7'b0, srq}, 8'h00);
    @(negedge clk); rst_n = 1;
    run("R12", 2);

    // R2: queue flag visible, no request with empty mask
    mav = 1; run("R2", 2);
    do_query("R2");
    chk("R2", "query mav", query_byte, 8'h10);
    // R5: enable bit 6 alone does nothing
    sre = 8'h40; run("R5", 3);
    chk("R5", "srq bit6 mask", {7'b0, srq}, 8'h00);
    // R6: enable mav
    sre = 8'h10; run("R6", 2);
    chk("R6", "srq set", {7'b0, srq}, 8'h01);
    // R7: poll reports and clears only request
    do_poll("R7");
    chk("R7", "poll byte", poll_byte, 8'h50);
    chk("R7", "srq cleared", {7'b0, srq}, 8'h00);
    do_query("R2");
    chk("R2", "mav kept after poll", query_byte, 8'h50);
    // R9: no re-request while summary stays high
    run("R9", 4);
    chk("R9", "no rerequest", {7'b0, srq}, 8'h00);
    mav = 0; run("R9", 2);
    mav = 1; run("R9", 2);
    chk("R9", "rerequest", {7'b0, srq}, 8'h01);
    // R8: query leaves request set
    do_query("R8");
    run("R8", 1);
    chk("R8", "srq kept", {7'b0, srq}, 8'h01);
    chk("R8", "query mss", query_byte, 8'h50);
    do_poll("R7"); mav = 0; run("R7", 2);
    // R3 / R11: standard events
    sre = 8'h20; std_en = 8'h04;
    std_set = 8'h01; step("R3"); std_set = 0; run("R3", 2);
    chk("R3", "disabled bit", {7'b0, srq}, 8'h00);
    std_set = 8'h04; step("R3"); std_set = 0; run("R11", 3);
    chk("R11", "sticky summary", {7'b0, srq}, 8'h01);
    do_query("R3");
    chk("R3", "query esb", query_byte, 8'h60);
    // R10: clear-status
    clr = 1; step("R10"); clr = 0; run("R10", 1);
    chk("R10", "srq cleared", {7'b0, srq}, 8'h00);
    do_query("R10");
    chk("R10", "events cleared", query_byte, 8'h00);
    std_set = 8'h04; step("R10"); std_set = 0; run("R10", 2);
    chk("R10", "mask kept", {7'b0, srq}, 8'h01);
    clr = 1; std_set = 8'h04; step("R10"); clr = 0; std_set = 0; run("R10", 2);
    do_query("R10");
    chk("R10", "clear beats set", query_byte, 8'h00);
    // R4: operation events, top bit
    sre = 8'h80; oper_en = 16'h8000;
    oper_set = 16'h0001; step("R4"); oper_set = 0; run("R4", 2);
    chk("R4", "disabled oper", {7'b0, srq}, 8'h00);
    oper_set = 16'h8000; step("R4"); oper_set = 0; run("R4", 2);
    do_query("R4");
    chk("R4", "query osb", query_byte, 8'hC0);
    // R7: poll coinciding with a summary rise
    clr = 1; step("R7"); clr = 0; sre = 8'h10; run("R7", 2);
    mav = 1; poll = 1; step("R7"); poll = 0; run("R7", 1);
    chk("R7", "rise beats poll", {7'b0, srq}, 8'h01);
    chk("R1", "low nibble poll", poll_byte & 8'h0F, 8'h00);
    do_query("R1");
    chk("R1", "low nibble query", query_byte & 8'h0F, 8'h00);
    run("R6", 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule